// File: doc/BRIEF.md
# Weighted-Share Fetch Thread Selector

This block decides, every cycle, the order in which the threads of a multithreaded front end compete for fetch bandwidth. For each thread it tracks how many instructions are in flight: fetched but not yet executed. It also holds a priority weight that software sets. Each weight defines a target share of the machine, equal to that thread's weight over the sum of all weights. The thread whose actual share of in-flight instructions lies furthest below its target is ranked first. The fetch unit reads the first two slots of the ranked list and takes up to eight instructions from those threads.

No divider is used. The fractions are compared through cross products, so each thread gets a signed key equal to its weight times the total count, minus its count times the total weight. When nothing is in flight, every key would be zero, so the weights alone decide the order. A thread that is quiesced, or that has no valid fetch path, is marked ineligible and falls to the bottom of the list. The ranking is combinational from the registered counters and weights, and from the eligibility input.

Top module: `wshare_fetch_sel`

## Requirements
- R1: After reset every weight is 1 and every in-flight count is 0. With all threads eligible, the ranked list is then thread 0, 1, 2, 3, and every slot is valid.
- R2: Each clock, a thread's count becomes its old count plus its fetch increment minus its execute decrement. The result saturates at 0 below and at 63 above. Increments and decrements each lie in the range 0 to 8.
- R3: When the priority write enable is high at a clock edge, the weight of the addressed thread takes the written 4-bit level from the next cycle onward. The weights of the other threads keep their values.
- R4: Among eligible threads, a thread with a larger key w_i·C_total − c_i·W_total appears in an earlier slot. Slot 0 is the first in the list.
- R5: Eligible threads with equal keys are ordered by ascending thread id.
- R6: When the sum of all counts is zero, eligible threads are ordered by descending weight, with ties going to the lower id.
- R7: Every ineligible thread comes after every eligible thread, and ineligible threads are in ascending id order. A slot's valid bit equals the eligibility of the thread in that slot.
- R8: A change of thread_elig changes the ranked list in the same cycle, with no clock edge in between.
- R9: With weights 4, 5, 1, 0, counts 25, 20, 5, 0, and thread 3 ineligible, the list is 1, 2, 0, 3 and the valid bits are 1, 1, 1, 0 for slots 0 to 3.
- R10: rank_tid carries one distinct thread id per slot, with slot p in bits [2p+1:2p], so every thread appears exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| fetch_inc | input | 16 | Instructions fetched this cycle per thread, 4 bits each, thread t in [4t+3:4t] |
| exec_dec | input | 16 | Instructions executed this cycle per thread, 4 bits each, same layout |
| prio_wr_en | input | 1 | Write a priority weight |
| prio_wr_tid | input | 2 | Thread whose weight is written |
| prio_wr_level | input | 4 | New weight |
| thread_elig | input | 4 | Per-thread eligibility, bit t for thread t |
| rank_tid | output | 8 | Ranked thread ids, slot p in [2p+1:2p] |
| rank_vld | output | 4 | Slot p holds an eligible thread |

## Verification
The bench keeps its own model of counts and weights and recomputes the full ranking each cycle. It compares this against the design during directed phases and a long random sweep.

The directed phases target specific corner cases:
- Saturation at both ends of a counter. A wrapping counter would make a nearly full thread look nearly empty, and it would jump to the top of the list.
- Ties in the keys. A design that broke ties the wrong way would swap equal threads.
- The all-zero count case. Without the weight fallback, the order would collapse to plain id order.
- Ineligible threads mixed into the list, and the worked three-weight example.
- Eligibility changes in mid-cycle. These expose a ranking that had been registered by mistake.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

  localparam int unsigned FSEL_NT       = 4;
  localparam int unsigned FSEL_WEIGHT_W = 4;
  localparam int unsigned FSEL_CNT_W    = 6;
  localparam int unsigned FSEL_STEP_MAX = 8;

  // Saturating update of an in-flight count.
  function automatic int fsel_sat(input int cur, input int up, input int dn, input int hi);
    int v;
    v = cur + up - dn;
    if (v < 0) v = 0;
    if (v > hi) v = hi;
    return v;
  endfunction

  // True when thread a must be ranked ahead of thread b.
  function automatic logic fsel_beats(input logic ea, input logic eb,
                                      input int ka, input int kb,
                                      input int ia, input int ib);
    if (ea != eb) return ea;
    if (!ea)      return (ia < ib);
    if (ka != kb) return (ka > kb);
    return (ia < ib);
  endfunction

endpackage

// File: rtl/fsel_ctr.sv
module fsel_ctr
  import fsel_pkg::*;
#(
  parameter int unsigned CNT_W    = FSEL_CNT_W,
  parameter int unsigned STEP_MAX = FSEL_STEP_MAX,
  localparam int unsigned STEP_W  = $clog2(STEP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] inc,
  input  logic [STEP_W-1:0] dec,
  output logic [CNT_W-1:0]  count
);

  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] count_nxt;
  logic             upd_en;

  always_comb begin
    upd_en    = (inc != '0) || (dec != '0);
    count_nxt = CNT_W'(fsel_sat(int'(count), int'(inc), int'(dec), CNT_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (upd_en) count <= count_nxt;
  end

  // R2: a count moves by no more than one step per cycle
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(count) <= int'($past(count)) + int'(STEP_MAX)) &&
             (int'(count) + int'(STEP_MAX) >= int'($past(count))));

  // R2: no activity leaves the count unchanged
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == '0 && dec == '0) |=> $stable(count));

endmodule

// File: rtl/fsel_wregs.sv
module fsel_wregs
  import fsel_pkg::*;
#(
  parameter int unsigned NT       = FSEL_NT,
  parameter int unsigned WEIGHT_W = FSEL_WEIGHT_W,
  localparam int unsigned TID_W   = $clog2(NT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [TID_W-1:0]       wr_tid,
  input  logic [WEIGHT_W-1:0]    wr_level,
  output logic [NT*WEIGHT_W-1:0] weights
);

  for (genvar t = 0; t < NT; t++) begin : g_w
    logic we;
    always_comb we = wr_en && (wr_tid == TID_W'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  weights[t*WEIGHT_W +: WEIGHT_W] <= WEIGHT_W'(1);
      else if (we) weights[t*WEIGHT_W +: WEIGHT_W] <= wr_level;
    end
  end

  // R3: weights change only through a write
  p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(weights));

  // R3: a write lands on the addressed thread
  p_wr_land_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> weights[$past(wr_tid)*WEIGHT_W +: WEIGHT_W] == $past(wr_level));

endmodule

// File: rtl/fsel_keys.sv
module fsel_keys
  import fsel_pkg::*;
#(
  parameter int unsigned NT       = FSEL_NT,
  parameter int unsigned WEIGHT_W = FSEL_WEIGHT_W,
  parameter int unsigned CNT_W    = FSEL_CNT_W,
  localparam int unsigned WSUM_W  = WEIGHT_W + $clog2(NT),
  localparam int unsigned CSUM_W  = CNT_W + $clog2(NT),
  localparam int unsigned PA_W    = WEIGHT_W + CSUM_W,
  localparam int unsigned PB_W    = CNT_W + WSUM_W,
  localparam int unsigned KEY_W   = ((PA_W > PB_W) ? PA_W : PB_W) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NT*WEIGHT_W-1:0] weights,
  input  logic [NT*CNT_W-1:0]    counts,
  output logic [NT*KEY_W-1:0]    keys
);

  logic [WSUM_W-1:0] w_total;
  logic [CSUM_W-1:0] c_total;

  always_comb begin
    w_total = '0;
    c_total = '0;
    for (int t = 0; t < int'(NT); t++) begin
      w_total = w_total + WSUM_W'(weights[t*WEIGHT_W +: WEIGHT_W]);
      c_total = c_total + CSUM_W'(counts[t*CNT_W +: CNT_W]);
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_key
    logic [KEY_W-1:0] prod_w;
    logic [KEY_W-1:0] prod_c;
    always_comb begin
      prod_w = KEY_W'(weights[t*WEIGHT_W +: WEIGHT_W]) * KEY_W'(c_total);
      prod_c = KEY_W'(counts[t*CNT_W +: CNT_W]) * KEY_W'(w_total);
      if (c_total == '0) keys[t*KEY_W +: KEY_W] = KEY_W'(weights[t*WEIGHT_W +: WEIGHT_W]);
      else               keys[t*KEY_W +: KEY_W] = prod_w - prod_c;
    end
  end

  int key_sum;
  always_comb begin
    key_sum = 0;
    for (int t = 0; t < int'(NT); t++)
      key_sum = key_sum + int'($signed(keys[t*KEY_W +: KEY_W]));
  end

  // R4: shares over target and under target cancel exactly
  p_key_balance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_total != '0) |-> (key_sum == 0));

endmodule

// File: rtl/fsel_rank.sv
module fsel_rank
  import fsel_pkg::*;
#(
  parameter int unsigned NT     = FSEL_NT,
  parameter int unsigned KEY_W  = 13,
  localparam int unsigned TID_W = $clog2(NT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NT*KEY_W-1:0] keys,
  input  logic [NT-1:0]       elig,
  output logic [NT*TID_W-1:0] rank_tid,
  output logic [NT-1:0]       rank_vld
);

  int               key_i [NT];
  logic [TID_W-1:0] pos   [NT];

  always_comb begin
    for (int t = 0; t < int'(NT); t++)
      key_i[t] = int'($signed(keys[t*KEY_W +: KEY_W]));
  end

  // Position of each thread = number of threads that beat it.
  always_comb begin
    for (int i = 0; i < int'(NT); i++) begin
      pos[i] = '0;
      for (int j = 0; j < int'(NT); j++) begin
        if (j != i && fsel_beats(elig[j], elig[i], key_i[j], key_i[i], j, i))
          pos[i] = pos[i] + TID_W'(1);
      end
    end
  end

  for (genvar p = 0; p < NT; p++) begin : g_slot
    always_comb begin
      rank_tid[p*TID_W +: TID_W] = '0;
      rank_vld[p]                = 1'b0;
      for (int i = 0; i < int'(NT); i++) begin
        if (pos[i] == TID_W'(p)) begin
          rank_tid[p*TID_W +: TID_W] = rank_tid[p*TID_W +: TID_W] | TID_W'(i);
          rank_vld[p]                = rank_vld[p] | elig[i];
        end
      end
    end
  end

  logic [NT-1:0] seen;
  int            k_top0, k_top1;
  always_comb begin
    seen = '0;
    for (int p = 0; p < int'(NT); p++)
      seen[rank_tid[p*TID_W +: TID_W]] = 1'b1;
    k_top0 = key_i[rank_tid[0 +: TID_W]];
    k_top1 = key_i[rank_tid[TID_W +: TID_W]];
  end

  // R10: the list is a permutation of the threads
  p_rank_perm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == NT);

  // R7: valid slots form a contiguous run starting at slot 0
  p_elig_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rank_vld + 1'b1) & rank_vld) == '0);

  // R7: number of valid slots matches number of eligible threads
  p_elig_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rank_vld) == $countones(elig));

  // R4: the two fetch picks are in key order
  p_top_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rank_vld[0] && rank_vld[1]) |-> (k_top0 >= k_top1));

endmodule

// File: rtl/wshare_fetch_sel.sv
module wshare_fetch_sel
  import fsel_pkg::*;
#(
  parameter int unsigned NT       = FSEL_NT,
  parameter int unsigned WEIGHT_W = FSEL_WEIGHT_W,
  parameter int unsigned CNT_W    = FSEL_CNT_W,
  parameter int unsigned STEP_MAX = FSEL_STEP_MAX,
  localparam int unsigned TID_W   = $clog2(NT),
  localparam int unsigned STEP_W  = $clog2(STEP_MAX + 1),
  localparam int unsigned WSUM_W  = WEIGHT_W + $clog2(NT),
  localparam int unsigned CSUM_W  = CNT_W + $clog2(NT),
  localparam int unsigned PA_W    = WEIGHT_W + CSUM_W,
  localparam int unsigned PB_W    = CNT_W + WSUM_W,
  localparam int unsigned KEY_W   = ((PA_W > PB_W) ? PA_W : PB_W) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NT*STEP_W-1:0] fetch_inc,
  input  logic [NT*STEP_W-1:0] exec_dec,
  input  logic                 prio_wr_en,
  input  logic [TID_W-1:0]     prio_wr_tid,
  input  logic [WEIGHT_W-1:0]  prio_wr_level,
  input  logic [NT-1:0]        thread_elig,
  output logic [NT*TID_W-1:0]  rank_tid,
  output logic [NT-1:0]        rank_vld
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  always_comb rst_n_int = rst_pipe[1];

  logic [NT*CNT_W-1:0]    counts;
  logic [NT*WEIGHT_W-1:0] weights;
  logic [NT*KEY_W-1:0]    keys;

  for (genvar t = 0; t < NT; t++) begin : g_ctr
    fsel_ctr #(
      .CNT_W    (CNT_W),
      .STEP_MAX (STEP_MAX)
    ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n_int),
      .inc   (fetch_inc[t*STEP_W +: STEP_W]),
      .dec   (exec_dec[t*STEP_W +: STEP_W]),
      .count (counts[t*CNT_W +: CNT_W])
    );
  end

  fsel_wregs #(
    .NT       (NT),
    .WEIGHT_W (WEIGHT_W)
  ) u_wregs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (prio_wr_en),
    .wr_tid   (prio_wr_tid),
    .wr_level (prio_wr_level),
    .weights  (weights)
  );

  fsel_keys #(
    .NT       (NT),
    .WEIGHT_W (WEIGHT_W),
    .CNT_W    (CNT_W)
  ) u_keys (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .weights (weights),
    .counts  (counts),
    .keys    (keys)
  );

  fsel_rank #(
    .NT    (NT),
    .KEY_W (KEY_W)
  ) u_rank (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .keys     (keys),
    .elig     (thread_elig),
    .rank_tid (rank_tid),
    .rank_vld (rank_vld)
  );

endmodule

// File: tb/wshare_fetch_sel_tb_top.sv
`timescale 1ns/1ps
module wshare_fetch_sel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] fetch_inc;
  logic [15:0] exec_dec;
  logic        prio_wr_en;
  logic [1:0]  prio_wr_tid;
  logic [3:0]  prio_wr_level;
  logic [3:0]  thread_elig;
  logic [7:0]  rank_tid;
  logic [3:0]  rank_vld;

  always #2.5 clk = ~clk;

  wshare_fetch_sel dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_inc     (fetch_inc),
    .exec_dec      (exec_dec),
    .prio_wr_en    (prio_wr_en),
    .prio_wr_tid   (prio_wr_tid),
    .prio_wr_level (prio_wr_level),
    .thread_elig   (thread_elig),
    .rank_tid      (rank_tid),
    .rank_vld      (rank_vld)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int m_cnt [4];
  int m_w   [4];
  logic [7:0] exp_tid;
  logic [3:0] exp_vld;
  bit done = 0;

  task automatic compute_exp();
    int ws, cs, best;
    int key [4];
    bit used [4];
    ws = 0; cs = 0;
    for (int t = 0; t < 4; t++) begin ws += m_w[t]; cs += m_cnt[t]; used[t] = 0; end
    for (int t = 0; t < 4; t++)
      key[t] = (cs == 0) ? m_w[t] : (m_w[t] * cs - m_cnt[t] * ws);
    exp_tid = '0; exp_vld = '0;
    for (int p = 0; p < 4; p++) begin
      best = -1;
      for (int i = 0; i < 4; i++) begin
        if (!used[i]) begin
          if (best < 0) best = i;
          else if (thread_elig[i] && !thread_elig[best]) best = i;
          else if (thread_elig[i] && thread_elig[best] && key[i] > key[best]) best = i;
        end
      end
      used[best] = 1;
      exp_tid[p*2 +: 2] = 2'(best);
      exp_vld[p] = thread_elig[best];
    end
  endtask

  task automatic check_now(input string tag);
    compute_exp();
    n_checks++;
    if (rank_tid !== exp_tid || rank_vld !== exp_vld) begin
      n_fail++;
      $display("FAIL %s: rank_tid=%h rank_vld=%b expected rank_tid=%h rank_vld=%b",
               tag, rank_tid, rank_vld, exp_tid, exp_vld);
    end
  endtask

  // One clock: inputs already set; model the edge, clear inputs, check.
  task automatic tick(input string tag);
    @(posedge clk);
    for (int t = 0; t < 4; t++) begin
      m_cnt[t] = m_cnt[t] + int'(fetch_inc[t*4 +: 4]) - int'(exec_dec[t*4 +: 4]);
      if (m_cnt[t] < 0)  m_cnt[t] = 0;
      if (m_cnt[t] > 63) m_cnt[t] = 63;
    end
    if (prio_wr_en) m_w[prio_wr_tid] = int'(prio_wr_level);
    @(negedge clk);
    fetch_inc = '0; exec_dec = '0; prio_wr_en = 1'b0;
    check_now(tag);
  endtask

  task automatic wr_prio(input int tid, input int lvl, input string tag);
    prio_wr_en = 1'b1; prio_wr_tid = 2'(tid); prio_wr_level = 4'(lvl);
    tick(tag);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; fetch_inc = '0; exec_dec = '0; prio_wr_en = 1'b0;
    prio_wr_tid = '0; prio_wr_level = '0; thread_elig = 4'b1111;
    for (int t = 0; t < 4; t++) begin m_cnt[t] = 0; m_w[t] = 1; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_now("R1 reset order");
    tick("R1 reset hold");

    // R6: zero counts, weights decide; R3: single write moves one thread
    wr_prio(0, 3, "R3 write t0");
    wr_prio(1, 9, "R3 write t1");
    wr_prio(2, 9, "R6 tie by id");
    wr_prio(3, 2, "R6 weight order");
    wr_prio(2, 12, "R3 write t2 only");
    wr_prio(0, 0, "R6 zero weight");

    // R9: worked example
    wr_prio(0, 4, "R9 setup"); wr_prio(1, 5, "R9 setup");
    wr_prio(2, 1, "R9 setup"); wr_prio(3, 0, "R9 setup");
    thread_elig = 4'b0111;
    fetch_inc = 16'h0588; tick("R9 build");
    fetch_inc = 16'h0088; tick("R9 build");
    fetch_inc = 16'h0048; tick("R9 build");
    fetch_inc = 16'h0001; tick("R9 build");
    check_now("R9 example");
    n_checks++;
    if (rank_tid !== 8'b11_00_10_01 || rank_vld !== 4'b0111) begin
      n_fail++;
      $display("FAIL R9: rank_tid=%b rank_vld=%b expected rank_tid=11001001 rank_vld=0111",
               rank_tid, rank_vld);
    end

    // R8: eligibility acts without a clock edge
    #1 thread_elig = 4'b1111; #1 check_now("R8 elig on");
    #1 thread_elig = 4'b1101; #1 check_now("R8 elig off t1");
    #1 thread_elig = 4'b0000; #1 check_now("R7 none eligible");
    @(negedge clk); thread_elig = 4'b1111;

    // R2: drain to zero (underflow clamp), then saturate high
    for (int t = 0; t < 4; t++) wr_prio(t, 1, "R2 equal weights");
    for (int k = 0; k < 5; k++) begin exec_dec = 16'h8888; tick("R2 drain"); end
    check_now("R5 equal keys id order");
    for (int k = 0; k < 10; k++) begin fetch_inc = 16'h0008; tick("R2 saturate t0"); end
    for (int k = 0; k < 7; k++)  begin fetch_inc = 16'h0080; tick("R2 fill t1"); end
    fetch_inc = 16'h0070; tick("R2 t1 at 63");
    exec_dec  = 16'h0008; tick("R2 t0 from 63");
    fetch_inc = 16'h0300; exec_dec = 16'h0000; tick("R2 t2 up");
    exec_dec  = 16'h0800; tick("R2 t2 underflow");
    fetch_inc = 16'h1100; tick("R2 t2 t3 equal");

    // R4: random sweep against the model
    for (int k = 0; k < 4000; k++) begin
      for (int t = 0; t < 4; t++) begin
        fetch_inc[t*4 +: 4] = 4'($urandom_range(8, 0));
        exec_dec[t*4 +: 4]  = 4'($urandom_range(8, 0));
      end
      if ($urandom_range(3, 0) == 0) begin
        prio_wr_en = 1'b1;
        prio_wr_tid = 2'($urandom_range(3, 0));
        prio_wr_level = 4'($urandom_range(15, 0));
      end
      if ($urandom_range(7, 0) == 0) thread_elig = 4'($urandom_range(15, 0));
      tick("R4 random sweep");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule